// File: doc/BRIEF.md
# Key Matrix Scanner with Snapshot Read-out

This block scans a 12 x 4 key matrix. The matrix shares its source lines with the segment lines of a display driver. One source line is active at a time, and each stays active for a fixed slot of clock cycles. Late in each slot the four return lines are sampled and stored in a 48-bit working array, ordered source-major. The matrix wiring is assumed to return the pressed keys of the active source on the four returns.

A pulse on `cycle_end` comes from the display timing. It marks the end of a display cycle and does three things at once:
- it copies the working array into a holding register;
- it latches the 4-bit general-purpose switch port;
- it restarts the scan at the first source.

A serial reader therefore always sees one consistent snapshot, even while the keys change. The reader loads the snapshot into a shifter and takes it one bit at a time, least significant bit first. The 48 bits form six bytes.

Top module: `keyscan_top`

## Requirements
- R1: After reset, exactly one of the 12 source lines is active at any time. With the default `SRC_ACTIVE_HIGH=1`, the active line is 1 and the others are 0.
- R2: After reset, or in the cycle after a `cycle_end` pulse, source 0 is active. Each source stays active for `SLOT_CYC` (default 8) cycles. The sources are driven in the order 0, 1, ..., 11, and the scan then wraps back to 0.
- R3: The four returns are sampled only at slot cycle `SAMPLE_OFS` (default 6, counted from 0 at the start of the slot). Return r of source s is stored at bit s*4+r.
- R4: On a clock edge with `cycle_end` high, the working array is copied into the holding register, and the scan restarts at source 0 in slot cycle 0. No return sample is taken on that edge.
- R5: The holding register changes only on a `cycle_end` edge. A read gives the last snapshot, whatever the keys do afterwards.
- R6: `sw_in` is captured into `sw_val` only on a `cycle_end` edge.
- R7: When `rd_load` is high, the holding register is copied into the read shifter, and `rd_bit` shows bit 0 after that edge. Each `rd_shift` moves the next bit to `rd_bit`, so bit n appears after n shifts. After 48 shifts, `rd_bit` is 0. `rd_load` wins when both inputs are high. Byte k of the read stream holds source 2k in bits 0-3 and source 2k+1 in bits 4-7.
- R8: Reset clears the working array, the holding register, `sw_val` and the read shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_end | input | 1 | One-cycle end-of-display-cycle pulse |
| key_in | input | 4 | Return lines of the key matrix |
| sw_in | input | 4 | General-purpose switch port |
| rd_load | input | 1 | Load the snapshot into the read shifter |
| rd_shift | input | 1 | Advance the read shifter by one bit |
| src_drv | output | 12 | Key-source drive, shared with the segment lines |
| sw_val | output | 4 | Switch port value latched at the last cycle end |
| rd_bit | output | 1 | Current serial read bit |

## Verification
The bench models the return lines so that they carry the true key data only at the sample cycle of each slot and the inverted data at every other cycle. A scanner that samples early or late therefore reads back complemented bits. Test patterns place keys on the first and last bit positions and on byte-distinct values. This exposes a swapped source or return order, or a wrong byte packing.

Keys and switches are changed after a snapshot, and the scan is left running for two full cycles without a pulse. A design that updates its holding register continuously would hand back the new data. Asserting load and shift together catches a design with the wrong priority, and a mid-cycle pulse checks that the scan really restarts at source 0.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
   // Flat position of return r of source s, source-major.
   function automatic int unsigned key_pos(int unsigned s, int unsigned r, int unsigned n_ret);
      return s * n_ret + r;
   endfunction
endpackage

// File: rtl/keyscan_seq.sv
module keyscan_seq #(
   parameter int unsigned NUM_SRC         = 12,
   parameter int unsigned SLOT_CYC        = 8,
   parameter int unsigned SAMPLE_OFS      = 6,
   parameter bit          SRC_ACTIVE_HIGH = 1'b1,
   localparam int unsigned SRC_W          = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int unsigned SLOT_W         = $clog2(SLOT_CYC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cycle_end,
   output logic [SRC_W-1:0]   src_idx,
   output logic               sample_stb,
   output logic [NUM_SRC-1:0] src_drv
);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYC - 1);
   localparam logic [SLOT_W-1:0] SMP_AT    = SLOT_W'(SAMPLE_OFS);
   localparam logic [SRC_W-1:0]  SRC_LAST  = SRC_W'(NUM_SRC - 1);

   generate
      if (SLOT_CYC < 2) begin : g_bad_slot
         $error("keyscan_seq: SLOT_CYC must be at least 2");
      end
      if (SAMPLE_OFS >= SLOT_CYC) begin : g_bad_ofs
         $error("keyscan_seq: SAMPLE_OFS must lie inside the slot");
      end
   endgenerate

   logic [SLOT_W-1:0]  slot_cnt;
   logic [NUM_SRC-1:0] drv_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_cnt <= '0;
         src_idx  <= '0;
      end else if (cycle_end) begin
         slot_cnt <= '0;
         src_idx  <= '0;
      end else if (slot_cnt == SLOT_LAST) begin
         slot_cnt <= '0;
         src_idx  <= (src_idx == SRC_LAST) ? '0 : src_idx + 1'b1;
      end else begin
         slot_cnt <= slot_cnt + 1'b1;
      end
   end

   assign sample_stb = (slot_cnt == SMP_AT) && !cycle_end;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_dec
      assign drv_hi[s] = (src_idx == SRC_W'(s));
   end

   generate
      if (SRC_ACTIVE_HIGH) begin : g_pol_hi
         assign src_drv = drv_hi;
      end else begin : g_pol_lo
         assign src_drv = ~drv_hi;
      end
   endgenerate

   assert_src_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cnt == SLOT_LAST && !cycle_end && src_idx != SRC_LAST)
      |=> (src_idx == $past(src_idx) + 1'b1));

   assert_src_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_cnt == SLOT_LAST && !cycle_end && src_idx == SRC_LAST) |=> (src_idx == '0));

   assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> (src_idx == '0 && slot_cnt == '0));
endmodule

// File: rtl/keyscan_capture.sv
module keyscan_capture #(
   parameter int unsigned NUM_SRC = 12,
   parameter int unsigned NUM_RET = 4,
   parameter int unsigned SW_W    = 4,
   localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int unsigned TOTAL  = NUM_SRC * NUM_RET
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cycle_end,
   input  logic               sample_stb,
   input  logic [SRC_W-1:0]   src_idx,
   input  logic [NUM_RET-1:0] key_in,
   input  logic [SW_W-1:0]    sw_in,
   output logic [TOTAL-1:0]   hold,
   output logic [SW_W-1:0]    sw_hold
);
   import keyscan_pkg::*;

   logic [TOTAL-1:0] work;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_row
      logic [NUM_RET-1:0] row;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row <= '0;
         else if (sample_stb && src_idx == SRC_W'(s))
            row <= key_in;
      end
      assign work[key_pos(s, 0, NUM_RET) +: NUM_RET] = row;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold    <= '0;
         sw_hold <= '0;
      end else if (cycle_end) begin
         hold    <= work;
         sw_hold <= sw_in;
      end
   end

   assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> $stable(hold));

   assert_sw_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> $stable(sw_hold));

   assert_no_sample_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |-> !sample_stb);
endmodule

// File: rtl/keyscan_readout.sv
module keyscan_readout #(
   parameter int unsigned TOTAL = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_load,
   input  logic             rd_shift,
   input  logic [TOTAL-1:0] hold,
   output logic             rd_bit
);
   logic [TOTAL-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh <= '0;
      else if (rd_load)
         sh <= hold;
      else if (rd_shift)
         sh <= {1'b0, sh[TOTAL-1:1]};
   end

   assign rd_bit = sh[0];

   assert_shift_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_load && !rd_shift) |=> $stable(sh));

   assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load |=> (rd_bit == $past(hold[0])));
endmodule

// File: rtl/keyscan_top.sv
module keyscan_top #(
   parameter int unsigned NUM_SRC         = 12,
   parameter int unsigned NUM_RET         = 4,
   parameter int unsigned SW_W            = 4,
   parameter int unsigned SLOT_CYC        = 8,
   parameter int unsigned SAMPLE_OFS      = 6,
   parameter bit          SRC_ACTIVE_HIGH = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cycle_end,
   input  logic [NUM_RET-1:0] key_in,
   input  logic [SW_W-1:0]    sw_in,
   input  logic               rd_load,
   input  logic               rd_shift,
   output logic [NUM_SRC-1:0] src_drv,
   output logic [SW_W-1:0]    sw_val,
   output logic               rd_bit
);
   localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned TOTAL = NUM_SRC * NUM_RET;

   logic [SRC_W-1:0] src_idx;
   logic             sample_stb;
   logic [TOTAL-1:0] hold;

   keyscan_seq #(
      .NUM_SRC(NUM_SRC), .SLOT_CYC(SLOT_CYC), .SAMPLE_OFS(SAMPLE_OFS),
      .SRC_ACTIVE_HIGH(SRC_ACTIVE_HIGH)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end),
      .src_idx(src_idx), .sample_stb(sample_stb), .src_drv(src_drv)
   );

   keyscan_capture #(
      .NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET), .SW_W(SW_W)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .sample_stb(sample_stb),
      .src_idx(src_idx), .key_in(key_in), .sw_in(sw_in),
      .hold(hold), .sw_hold(sw_val)
   );

   keyscan_readout #(.TOTAL(TOTAL)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_load(rd_load), .rd_shift(rd_shift),
      .hold(hold), .rd_bit(rd_bit)
   );

   assert_one_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(SRC_ACTIVE_HIGH ? src_drv : ~src_drv));
endmodule

// File: tb/tb_keyscan_top.sv
`timescale 1ns/1ps
module tb_keyscan_top;
   localparam int NS = 12, NR = 4, TOT = 48, SLOT = 8, SMP = 6;

   localparam int NPAT = 4;
   localparam logic [47:0] PATS [NPAT] = '{
      48'h0000_0000_0001, 48'h8000_0000_0000,
      48'hA5C3_5A3C_96E1, 48'h0605_0403_0201 };
   localparam logic [3:0] SWS [NPAT] = '{4'h1, 4'h8, 4'hA, 4'h5};

   logic clk = 1'b0, rst_n = 1'b0, cycle_end = 1'b0, rd_load = 1'b0, rd_shift = 1'b0;
   logic [3:0] key_in, sw_in = 4'h0, sw_val;
   logic [11:0] src_drv;
   logic rd_bit;
   logic [47:0] pressed = '0;
   logic [2:0] ph;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   keyscan_top dut (
      .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .key_in(key_in),
      .sw_in(sw_in), .rd_load(rd_load), .rd_shift(rd_shift),
      .src_drv(src_drv), .sw_val(sw_val), .rd_bit(rd_bit));

   // Bench's own slot phase, built from R2/R4 timing.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= '0;
      else if (cycle_end) ph <= '0;
      else ph <= ph + 3'd1;
   end

   // Matrix model: true data only at the sample cycle, inverted otherwise (R3).
   always_comb begin
      logic [3:0] m;
      m = '0;
      for (int s = 0; s < NS; s++)
         if (src_drv[s]) m |= pressed[s*NR +: NR];
      key_in = (ph == 3'(SMP)) ? m : ~m;
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_ce();
      cycle_end = 1'b1; tick(); cycle_end = 1'b0;
   endtask

   task automatic full_scan();
      pulse_ce();
      repeat (NS*SLOT - 1) tick();
      pulse_ce();
   endtask

   task automatic read_all(output logic [47:0] got);
      rd_load = 1'b1; tick(); rd_load = 1'b0;
      for (int i = 0; i < TOT; i++) begin
         got[i] = rd_bit;
         rd_shift = 1'b1; tick(); rd_shift = 1'b0;
      end
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [47:0] got;
      int bad;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R8 / R1: reset state
      check(sw_val == 4'h0, "R8 sw_val after reset", 64'(sw_val), 0);
      check(rd_bit == 1'b0, "R8 rd_bit after reset", 64'(rd_bit), 0);
      read_all(got);
      check(got == '0, "R8 snapshot after reset", 64'(got), 0);

      // R1 / R2: source order, dwell and wrap
      pulse_ce();
      bad = 0;
      for (int k = 0; k < NS*SLOT; k++) begin
         if (src_drv != 12'(1 << (k / SLOT))) bad++;
         tick();
      end
      check(bad == 0, "R1 R2 source sequence mismatches", 64'(bad), 0);
      check(src_drv == 12'h001, "R2 wrap to source 0", 64'(src_drv), 1);

      // Table walk: R3 R4 R6 R7
      for (int i = 0; i < NPAT; i++) begin
         pressed = PATS[i];
         sw_in = SWS[i];
         full_scan();
         check(sw_val == SWS[i], "R6 switch latched at cycle end", 64'(sw_val), 64'(SWS[i]));
         read_all(got);
         check(got == PATS[i], "R3 R4 snapshot bits", 64'(got), 64'(PATS[i]));
         check(rd_bit == 1'b0, "R7 zero after 48 shifts", 64'(rd_bit), 0);
      end

      // R7 byte packing of last pattern: byte k == k+1
      bad = 0;
      for (int k = 0; k < 6; k++)
         if (got[8*k +: 8] != 8'(k + 1)) bad++;
      check(bad == 0, "R7 byte packing mismatches", 64'(bad), 0);

      // R7 load wins over shift (bit0=1, bit1=0)
      rd_load = 1'b1; rd_shift = 1'b1; tick(); rd_load = 1'b0; rd_shift = 1'b0;
      check(rd_bit == 1'b1, "R7 load priority", 64'(rd_bit), 1);
      rd_shift = 1'b1; tick(); rd_shift = 1'b0;
      check(rd_bit == 1'b0, "R7 one shift gives bit1", 64'(rd_bit), 0);

      // R5 / R6: keys and switches change, no cycle end
      pressed = ~PATS[NPAT-1];
      sw_in = ~SWS[NPAT-1];
      repeat (2*NS*SLOT) tick();
      read_all(got);
      check(got == PATS[NPAT-1], "R5 snapshot held", 64'(got), 64'(PATS[NPAT-1]));
      check(sw_val == SWS[NPAT-1], "R6 switch held", 64'(sw_val), 64'(SWS[NPAT-1]));

      // R4: mid-cycle pulse restarts scan
      pulse_ce();
      repeat (20) tick();
      check(src_drv == 12'h004, "R2 source after 20 cycles", 64'(src_drv), 4);
      pulse_ce();
      check(src_drv == 12'h001, "R4 restart at source 0", 64'(src_drv), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule